// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Controller

This block is the bus master for a cartridge whose low address byte and data byte share one 8-bit bus. A client hands it one single-byte transfer at a time: a read or a write, a 22-bit address, and a target region. The region is the mask ROM, the battery-backed SRAM, or the internal RAM/IO window of the cartridge's own processor. The controller places address bits 21..8 on dedicated lines. It sends the low byte over the shared bus into an external transparent latch, pulsing a latch-enable strobe. It then either releases the bus and pulses the output-enable strobe to read, or drives write data and pulses the write strobe.

The region is chosen with two active-low select lines that feed a NAND gate on the cartridge. With both lines high, the ROM drives the bus. Select A low picks the SRAM. Select B low picks the processor window. A write to the processor window first gives a short low-then-high pulse on select A, then asserts select B. Each phase length is a parameter counted in system clocks, so the same block can meet the slow ROM access time (300 clocks at 100 MHz, about 3 us) and the short and long write pulses. The client sees a busy flag from acceptance to completion and a one-cycle done pulse with the read byte.

Top module: `cart_bus_ctrl`

## Requirements
- R1: After reset and whenever the block is not busy, `le` is low, `ad_oe` is low, and `oe_n`, `we_n`, `sel_a_n` and `sel_b_n` are all high.
- R2: Region codes are 2'b00 ROM, 2'b01 SRAM, 2'b10 processor window and 2'b11 ROM. For ROM neither select goes low. For SRAM only `sel_a_n` goes low. For the processor window `sel_b_n` goes low. The two selects are never low together. The select is held low from the first cycle of the address phase until the release phase ends.
- R3: Bits 21..8 of the address appear on `cart_addr_hi`. Bits 7..0 are driven on `ad_out` with `ad_oe` high while `le` is high for T_LE cycles. The bus keeps the address for T_HOLD further cycles after `le` falls.
- R4: On a read, `ad_oe` is low for T_TURN (at least 1) cycles before `oe_n` falls. `ad_oe` is never high while `oe_n` is low.
- R5: On a read, `oe_n` is low for T_RD_ROM cycles for the ROM regions and T_RD_RAM cycles for the others. `rd_data` holds the bus value seen in the last low cycle of `oe_n` and is valid while `done` is high.
- R6: On a write, `ad_out` carries the write data with `ad_oe` high while `we_n` is low. `we_n` is low for T_WE_IO cycles for the processor window and T_WE_RAM cycles for the other regions. Data and select stay driven for T_REL cycles after `we_n` rises.
- R7: A write to the processor window starts with `sel_a_n` low for T_PRE cycles, then high for T_PRE cycles, before `le` rises. No other transfer pulses `sel_a_n` unless it targets SRAM.
- R8: After `oe_n` or `we_n` rises, the select stays low for T_REL cycles. All strobes are then inactive for T_GAP cycles before `done`. For ROM transfers, which use no select, T_REL + T_GAP inactive cycles precede `done`.
- R9: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle through the `done` cycle. `done` lasts exactly one cycle and `busy` is low after it. A request presented while `busy` is high is ignored and causes no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Target region code |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Read result |
| cart_addr_hi | output | 14 | Address bits 21..8 to the cartridge |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| le | output | 1 | Address latch enable, captured on its fall |
| oe_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| sel_a_n | output | 1 | Region select A, active low |
| sel_b_n | output | 1 | Region select B, active low |

## Verification
The hardest case to reach from the ports is a request that arrives while a transfer is running. It must leave no trace at all. The bench raises `req_valid` with an SRAM write partway through a long ROM read and holds it for several cycles. It then reads that SRAM byte back and expects the old value. The scoreboard also reports a completion that has no queued request as a failure. The processor-window write, with its select-A precursor pulse, is checked by counting low cycles on each select for each transfer.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int unsigned CBC_ADDR_W = 22;
  localparam int unsigned CBC_DATA_W = 8;
  localparam int unsigned CBC_LO_W   = 8;
  localparam int unsigned CBC_HI_W   = CBC_ADDR_W - CBC_LO_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_LO,
    ST_PRE_HI,
    ST_ADDR,
    ST_HOLD,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_REL,
    ST_GAP,
    ST_DONE
  } cbc_state_e;

  typedef enum logic [1:0] {
    RG_ROM     = 2'b00,
    RG_SRAM    = 2'b01,
    RG_IOWIN   = 2'b10,
    RG_ROM_ALT = 2'b11
  } cbc_region_e;

  typedef struct packed {
    logic                  write;
    cbc_region_e           region;
    logic [CBC_ADDR_W-1:0] addr;
    logic [CBC_DATA_W-1:0] wdata;
  } cbc_req_t;

  typedef struct packed {
    logic                  le;
    logic                  oe_n;
    logic                  we_n;
    logic                  sel_a_n;
    logic                  sel_b_n;
    logic                  bus_oe;
    logic [CBC_DATA_W-1:0] bus_out;
  } cbc_pins_t;

  localparam cbc_pins_t CBC_PINS_IDLE = '{
    le: 1'b0, oe_n: 1'b1, we_n: 1'b1, sel_a_n: 1'b1, sel_b_n: 1'b1,
    bus_oe: 1'b0, bus_out: '0
  };

endpackage

// File: rtl/cbc_phase_timer.sv
module cbc_phase_timer #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/cbc_sequencer.sv
module cbc_sequencer
  import cbc_pkg::*;
#(
  parameter int unsigned T_PRE    = 2,
  parameter int unsigned T_LE     = 2,
  parameter int unsigned T_HOLD   = 1,
  parameter int unsigned T_TURN   = 1,
  parameter int unsigned T_RD_ROM = 300,
  parameter int unsigned T_RD_RAM = 4,
  parameter int unsigned T_WE_RAM = 24,
  parameter int unsigned T_WE_IO  = 74,
  parameter int unsigned T_REL    = 2,
  parameter int unsigned T_GAP    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  cbc_req_t   req_nx,
  output cbc_state_e state_q,
  output cbc_state_e state_d,
  output logic       phase_end
);

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned MAXP = max2(
    max2(max2(T_RD_ROM, T_WE_IO), max2(T_RD_RAM, T_WE_RAM)),
    max2(max2(T_PRE, T_LE), max2(max2(T_HOLD, T_TURN), max2(T_REL, T_GAP))));
  localparam int unsigned CW = $clog2(MAXP + 1);

  function automatic logic [CW-1:0] phase_len(cbc_state_e st, cbc_req_t r);
    int unsigned n;
    logic is_rom;
    logic is_io;
    is_rom = (r.region == RG_ROM) || (r.region == RG_ROM_ALT);
    is_io  = (r.region == RG_IOWIN);
    case (st)
      ST_PRE_LO, ST_PRE_HI: n = T_PRE;
      ST_ADDR:              n = T_LE;
      ST_HOLD:              n = T_HOLD;
      ST_TURN:              n = T_TURN;
      ST_READ:              n = is_rom ? T_RD_ROM : T_RD_RAM;
      ST_WRITE:             n = is_io ? T_WE_IO : T_WE_RAM;
      ST_REL:               n = T_REL;
      ST_GAP:               n = T_GAP;
      default:              n = 1;
    endcase
    return CW'(n - 1);
  endfunction

  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = (req_nx.write && (req_nx.region == RG_IOWIN)) ? ST_PRE_LO : ST_ADDR;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: begin
        if (phase_end) begin
          case (state_q)
            ST_PRE_LO: state_d = ST_PRE_HI;
            ST_PRE_HI: state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_HOLD;
            ST_HOLD:   state_d = req_nx.write ? ST_WRITE : ST_TURN;
            ST_TURN:   state_d = ST_READ;
            ST_READ:   state_d = ST_REL;
            ST_WRITE:  state_d = ST_REL;
            ST_REL:    state_d = ST_GAP;
            ST_GAP:    state_d = ST_DONE;
            default:   state_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign tmr_val  = phase_len(state_d, req_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  cbc_phase_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (phase_end)
  );

endmodule

// File: rtl/cbc_pin_drv.sv
module cbc_pin_drv
  import cbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cbc_state_e state_d,
  input  cbc_req_t   req_nx,
  output cbc_pins_t  pins_q
);

  cbc_pins_t pins_d;
  logic      sel_window;
  logic      addr_phase;

  always_comb begin
    addr_phase = (state_d == ST_ADDR) || (state_d == ST_HOLD);
    sel_window = addr_phase || (state_d == ST_TURN) || (state_d == ST_READ) ||
                 (state_d == ST_WRITE) || (state_d == ST_REL);
    pins_d         = CBC_PINS_IDLE;
    pins_d.le      = (state_d == ST_ADDR);
    pins_d.oe_n    = (state_d != ST_READ);
    pins_d.we_n    = (state_d != ST_WRITE);
    pins_d.bus_oe  = addr_phase ||
                     (req_nx.write && ((state_d == ST_WRITE) || (state_d == ST_REL)));
    pins_d.bus_out = addr_phase ? req_nx.addr[CBC_LO_W-1:0] : req_nx.wdata;
    pins_d.sel_a_n = !((state_d == ST_PRE_LO) ||
                       (sel_window && (req_nx.region == RG_SRAM)));
    pins_d.sel_b_n = !(sel_window && (req_nx.region == RG_IOWIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= CBC_PINS_IDLE;
    end else begin
      pins_q <= pins_d;
    end
  end

endmodule

// File: rtl/cart_bus_ctrl.sv
module cart_bus_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned T_PRE    = 2,
  parameter int unsigned T_LE     = 2,
  parameter int unsigned T_HOLD   = 1,
  parameter int unsigned T_TURN   = 1,
  parameter int unsigned T_RD_ROM = 300,
  parameter int unsigned T_RD_RAM = 4,
  parameter int unsigned T_WE_RAM = 24,
  parameter int unsigned T_WE_IO  = 74,
  parameter int unsigned T_REL    = 2,
  parameter int unsigned T_GAP    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_region,
  input  logic [CBC_ADDR_W-1:0] req_addr,
  input  logic [CBC_DATA_W-1:0] req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [CBC_DATA_W-1:0] rd_data,
  output logic [CBC_HI_W-1:0]   cart_addr_hi,
  output logic [CBC_DATA_W-1:0] ad_out,
  output logic                  ad_oe,
  input  logic [CBC_DATA_W-1:0] ad_in,
  output logic                  le,
  output logic                  oe_n,
  output logic                  we_n,
  output logic                  sel_a_n,
  output logic                  sel_b_n
);

  cbc_state_e state_q;
  cbc_state_e state_d;
  logic       phase_end;
  logic       accept;
  cbc_req_t   req_q;
  cbc_req_t   req_in;
  cbc_req_t   req_nx;
  cbc_pins_t  pins_q;
  logic [CBC_DATA_W-1:0] rdata_q;
  logic       capture_en;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    req_in.write  = req_write;
    req_in.region = cbc_region_e'(req_region);
    req_in.addr   = req_addr;
    req_in.wdata  = req_wdata;
    req_nx        = accept ? req_in : req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (accept) begin
      req_q <= req_in;
    end
  end

  cbc_sequencer #(
    .T_PRE(T_PRE), .T_LE(T_LE), .T_HOLD(T_HOLD), .T_TURN(T_TURN),
    .T_RD_ROM(T_RD_ROM), .T_RD_RAM(T_RD_RAM), .T_WE_RAM(T_WE_RAM),
    .T_WE_IO(T_WE_IO), .T_REL(T_REL), .T_GAP(T_GAP)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .req_nx    (req_nx),
    .state_q   (state_q),
    .state_d   (state_d),
    .phase_end (phase_end)
  );

  cbc_pin_drv pins_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .req_nx  (req_nx),
    .pins_q  (pins_q)
  );

  assign capture_en = (state_q == ST_READ) && phase_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_en) begin
      rdata_q <= ad_in;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign rd_data      = rdata_q;
  assign cart_addr_hi = req_q.addr[CBC_ADDR_W-1:CBC_LO_W];
  assign ad_out       = pins_q.bus_out;
  assign ad_oe        = pins_q.bus_oe;
  assign le           = pins_q.le;
  assign oe_n         = pins_q.oe_n;
  assign we_n         = pins_q.we_n;
  assign sel_a_n      = pins_q.sel_a_n;
  assign sel_b_n      = pins_q.sel_b_n;

endmodule

// File: rtl/cart_bus_ctrl_chk.sv
module cart_bus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic ad_oe,
  input logic le,
  input logic oe_n,
  input logic we_n,
  input logic sel_a_n,
  input logic sel_b_n
);

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (oe_n && we_n && sel_a_n && sel_b_n && !le && !ad_oe)); // R1
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_a_n && !sel_b_n)); // R2
  AST_LE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> ad_oe); // R3
  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(ad_oe)); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n)); // R5
  AST_WE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> ad_oe); // R6
  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ad_oe); // R6
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R9

endmodule

bind cart_bus_ctrl cart_bus_ctrl_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .ad_oe     (ad_oe),
  .le        (le),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .sel_a_n   (sel_a_n),
  .sel_b_n   (sel_b_n)
);

// File: tb/cart_bus_ctrl_tb_top.sv
module cart_bus_ctrl_tb_top;

  localparam int T_PRE    = 2;
  localparam int T_LE     = 2;
  localparam int T_HOLD   = 1;
  localparam int T_TURN   = 1;
  localparam int T_RD_ROM = 300;
  localparam int T_RD_RAM = 4;
  localparam int T_WE_RAM = 24;
  localparam int T_WE_IO  = 74;
  localparam int T_REL    = 2;
  localparam int T_GAP    = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_region;
  logic [21:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy;
  logic        done;
  logic [7:0]  rd_data;
  logic [13:0] cart_addr_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        le;
  logic        oe_n;
  logic        we_n;
  logic        sel_a_n;
  logic        sel_b_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  cart_bus_ctrl #(
    .T_PRE(T_PRE), .T_LE(T_LE), .T_HOLD(T_HOLD), .T_TURN(T_TURN),
    .T_RD_ROM(T_RD_ROM), .T_RD_RAM(T_RD_RAM), .T_WE_RAM(T_WE_RAM),
    .T_WE_IO(T_WE_IO), .T_REL(T_REL), .T_GAP(T_GAP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_region(req_region), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .cart_addr_hi(cart_addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .le(le), .oe_n(oe_n),
    .we_n(we_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- cartridge model ----------------
  logic [7:0] sram_m [256];
  logic [7:0] io_m   [256];
  logic [7:0] lat_lo;
  logic [21:0] cart_addr;

  function automatic logic [7:0] rom_fn(logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  initial begin
    lat_lo = 8'h00;
    for (int i = 0; i < 256; i++) begin
      sram_m[i] = 8'h00;
      io_m[i]   = 8'h00;
    end
  end

  always @(negedge le) lat_lo <= ad_out;
  assign cart_addr = {cart_addr_hi, lat_lo};

  always_comb begin
    if (oe_n) ad_in = 8'hFF;
    else if (!sel_a_n) ad_in = sram_m[cart_addr[7:0]];
    else if (!sel_b_n) ad_in = io_m[cart_addr[7:0]];
    else ad_in = rom_fn(cart_addr);
  end

  always @(posedge we_n) begin
    if (rst_n && ad_oe) begin
      if (!sel_a_n) sram_m[cart_addr[7:0]] = ad_out;
      else if (!sel_b_n) io_m[cart_addr[7:0]] = ad_out;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          wr;
    bit [1:0]    rg;
    bit [21:0]   addr;
    bit [7:0]    exp_rd;
    int          exp_oe;
    int          exp_we;
    int          exp_sa;
    int          exp_sb;
    int          exp_gap;
  } item_t;

  item_t exp_q[$];
  bit [7:0] ref_sram [256];
  bit [7:0] ref_io   [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int  le_c, oe_c, we_c, sa_c, sb_c, gap_c;
  bit  fight;
  logic [21:0] mon_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "done without request", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(mon_addr == it.addr, "R3", "latched address", int'(mon_addr), int'(it.addr));
          chk(le_c == T_LE, "R3", "le high cycles", le_c, T_LE);
          if (!it.wr) begin
            chk(rd_data == it.exp_rd, "R5", "read data", int'(rd_data), int'(it.exp_rd));
            chk(oe_c == it.exp_oe, "R5", "oe low cycles", oe_c, it.exp_oe);
            chk(!fight, "R4", "bus driven during oe", int'(fight), 0);
          end else begin
            chk(we_c == it.exp_we, "R6", "we low cycles", we_c, it.exp_we);
          end
          if (it.wr && it.rg == 2'b10)
            chk(sa_c == it.exp_sa, "R7", "sel_a precursor cycles", sa_c, it.exp_sa);
          else
            chk(sa_c == it.exp_sa, "R2", "sel_a low cycles", sa_c, it.exp_sa);
          chk(sb_c == it.exp_sb, "R2", "sel_b low cycles", sb_c, it.exp_sb);
          chk(gap_c == it.exp_gap, "R8", "quiet cycles before done", gap_c, it.exp_gap);
        end
        le_c = 0; oe_c = 0; we_c = 0; sa_c = 0; sb_c = 0; gap_c = 0; fight = 0;
      end else begin
        if (le) begin
          le_c++;
          mon_addr = {cart_addr_hi, ad_out};
        end
        if (!oe_n) oe_c++;
        if (!we_n) we_c++;
        if (!sel_a_n) sa_c++;
        if (!sel_b_n) sb_c++;
        if (!oe_n && ad_oe) fight = 1;
        if (le || !oe_n || !we_n || !sel_a_n || !sel_b_n) gap_c = 0;
        else gap_c++;
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit wr, input bit [1:0] rg, input bit [21:0] addr,
                        input bit [7:0] wd, input bit inject);
    item_t it;
    bit is_rom, is_io, is_sram;
    int core;
    is_rom  = (rg == 2'b00) || (rg == 2'b11);
    is_io   = (rg == 2'b10);
    is_sram = (rg == 2'b01);
    core = T_LE + T_HOLD + T_REL +
           (wr ? (is_io ? T_WE_IO : T_WE_RAM) : (T_TURN + (is_rom ? T_RD_ROM : T_RD_RAM)));
    it.wr = wr; it.rg = rg; it.addr = addr;
    it.exp_oe  = wr ? 0 : (is_rom ? T_RD_ROM : T_RD_RAM);
    it.exp_we  = wr ? (is_io ? T_WE_IO : T_WE_RAM) : 0;
    it.exp_sa  = is_sram ? core : ((is_io && wr) ? T_PRE : 0);
    it.exp_sb  = is_io ? core : 0;
    it.exp_gap = is_rom ? (T_REL + T_GAP) : T_GAP;
    if (is_rom)       it.exp_rd = rom_fn(addr);
    else if (is_sram) it.exp_rd = ref_sram[addr[7:0]];
    else              it.exp_rd = ref_io[addr[7:0]];
    if (wr && is_sram) ref_sram[addr[7:0]] = wd;
    if (wr && is_io)   ref_io[addr[7:0]]   = wd;

    @(negedge clk);
    while (busy) @(negedge clk);
    exp_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_region = rg; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_region = 2'b01;
      req_addr = 22'h000012; req_wdata = 8'hEE;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
    chk(done == 1'b0, "R9", "done single cycle", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ref_sram[i] = 8'h00;
      ref_io[i]   = 8'h00;
    end
    le_c = 0; oe_c = 0; we_c = 0; sa_c = 0; sb_c = 0; gap_c = 0; fight = 0;
    mon_addr = '0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_region = 2'b00;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(le == 1'b0 && ad_oe == 1'b0, "R1", "le/ad_oe in reset", {30'd0, le, ad_oe}, 0);
    chk(oe_n && we_n && sel_a_n && sel_b_n, "R1", "strobes in reset",
        {28'd0, oe_n, we_n, sel_a_n, sel_b_n}, 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R1", "busy/done after reset", {30'd0, busy, done}, 0);
    chk(oe_n && we_n && sel_a_n && sel_b_n && !le, "R1", "idle levels",
        {27'd0, oe_n, we_n, sel_a_n, sel_b_n, le}, 30);

    do_req(1'b0, 2'b00, 22'h000000, 8'h00, 1'b0);   // ROM, R5
    do_req(1'b0, 2'b00, 22'h3FFFFF, 8'h00, 1'b0);   // ROM top, R3
    do_req(1'b0, 2'b11, 22'h2ABCDE, 8'h00, 1'b0);   // ROM alias code, R2
    do_req(1'b1, 2'b01, 22'h000012, 8'hA5, 1'b0);   // SRAM write, R6
    do_req(1'b1, 2'b01, 22'h007F80, 8'h3C, 1'b0);   // SRAM write, R6
    do_req(1'b0, 2'b01, 22'h000012, 8'h00, 1'b0);   // SRAM read, R5
    do_req(1'b0, 2'b01, 22'h007F80, 8'h00, 1'b0);   // SRAM read, R5
    do_req(1'b1, 2'b10, 22'h00FFFF, 8'h28, 1'b0);   // window write, R7
    do_req(1'b1, 2'b10, 22'h00FEC1, 8'h77, 1'b0);   // window write, R7
    do_req(1'b0, 2'b10, 22'h00FFFF, 8'h00, 1'b0);   // window read, R2
    do_req(1'b0, 2'b10, 22'h00FEC1, 8'h00, 1'b0);   // window read, R2
    do_req(1'b1, 2'b00, 22'h001234, 8'h11, 1'b0);   // ROM-region write, R6
    do_req(1'b0, 2'b00, 22'h001234, 8'h00, 1'b0);   // ROM unchanged, R2
    do_req(1'b0, 2'b00, 22'h155AA0, 8'h00, 1'b1);   // request during busy, R9
    do_req(1'b0, 2'b01, 22'h000012, 8'h00, 1'b0);   // must still read A5, R9

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "pending scoreboard items", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule